// File: doc/BRIEF.md
# Eye-Mask Violation Error Counter

This block turns slicer samples taken at the two vertical edges of an eye mask into a slow, toggling error-rate signal. Each slicer pair compares the data against an upper and a lower threshold. When the two decisions disagree at a sampling instant, a data trace has passed through the mask. Samples come from an early phase, which marks the left mask edge, and from a late phase, which marks the right mask edge. Because the sampling clocks run at half rate, each phase delivers one sample taken on the rising edge and one taken on the falling edge.

Each mask edge has its own path. A path flags the rising-edge and falling-edge violations separately, aligns the two flags into one clock cycle and ORs them. It then divides the merged stream by a fixed factor of 16. The retimed outputs of the two paths are ORed together and passed to a divider whose ratio is chosen by a 2-bit code. The divided result drives a toggle flop. The mask error rate is then 16 × ratio × f_toggle / bit_rate. Either path can be switched off, which lets the two sides of an asymmetric eye be measured one at a time.

All inputs are taken to be already captured into the `clk_i` domain. The falling-edge sample arrives half a cycle ahead of the rising-edge sample.

Top module: `eom_err_counter`

## Requirements
- R1: For each path, a violation at one sampling instant is the XOR of the high-slicer bit and the low-slicer bit. In each pair of slicer ports, bit 0 is the rising-edge sample and bit 1 is the falling-edge sample. Equal bits never count.
- R2: The rising-edge and falling-edge violations are detected separately and aligned into one cycle. Violations on both bits in the same cycle count as one merged event.
- R3: When `en_early_i` (or `en_late_i`) is low, the early (or late) path contributes no events.
- R4: Each path emits one prescaled event for every 16 merged events. The 16th event produces it, and the first 15 produce none.
- R5: The prescaled events of the two paths are ORed after retiming. When both paths emit in the same cycle, that counts as one combined event.
- R6: The divide code selects the ratio: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. `err_tgl_o` toggles once per ratio combined events.
- R7: While `clr_i` is high at a rising edge, the prescalers, the divider counter and `err_tgl_o` clear to 0 and the divide code is loaded from `div_sel_i`. A change on `div_sel_i` without `clr_i` has no effect.
- R8: After an asynchronous reset, `err_tgl_o` is 0, the prescalers and divider are empty, and the divide code is 00 (ratio 1).
- R9: Take a violation that completes a divided count. Call the rising edge that samples it the first edge. `err_tgl_o` changes at the fifth edge and stays unchanged at the second, third and fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate sampling clock domain |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear; loads the divide code |
| en_early_i | input | 1 | Enables the early (left edge) path |
| en_late_i | input | 1 | Enables the late (right edge) path |
| div_sel_i | input | 2 | Divide code: 00=1, 01=4, 10=16, 11=64 |
| early_hi_i | input | 2 | Early-phase high-slicer samples, bit0 rising, bit1 falling |
| early_lo_i | input | 2 | Early-phase low-slicer samples, bit0 rising, bit1 falling |
| late_hi_i | input | 2 | Late-phase high-slicer samples, bit0 rising, bit1 falling |
| late_lo_i | input | 2 | Late-phase low-slicer samples, bit0 rising, bit1 falling |
| err_tgl_o | output | 1 | Toggle output; one change per divided error count |

## Verification
The assertions assume that the slicer ports and the enables hold known values at every rising edge after reset. The pipeline checks also assume that `clr_i` is raised only when no event is in flight.

The stimulus changes inputs only on falling clock edges and draws slicer bits at random, with a bias toward agreement so that violations stay sparse. Before every clear, the stimulus holds the slicers idle for several cycles so that the four-stage pipeline has drained.

// File: rtl/eom_err_pkg.sv
package eom_err_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned NPATH  = 2;
  localparam int unsigned DIV_CW = 2 * ((1 << SEL_W) - 1);

  // ratio = 4^sel
  function automatic logic [DIV_CW-1:0] ratio_m1(input logic [SEL_W-1:0] sel);
    logic [DIV_CW:0] r;
    r = ({{DIV_CW{1'b0}}, 1'b1} << (2 * sel));
    return r[DIV_CW-1:0] - 1'b1;
  endfunction
endpackage

// File: rtl/eom_mask_path.sv
module eom_mask_path #(
  parameter int unsigned PRE_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] hi_i,
  input  logic [1:0] lo_i,
  output logic       evt_o
);
  logic             rise_q, fall_q, merged_q, pulse_q;
  logic [PRE_W-1:0] pcnt_q;
  logic [1:0]       warm_q;

  // both flags land in one register stage; the falling sample is
  // already half a cycle older, so this is its rising-edge retime
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
      merged_q <= 1'b0;
      pulse_q  <= 1'b0;
      pcnt_q   <= '0;
    end else begin
      rise_q   <= en_i & (hi_i[0] ^ lo_i[0]);
      fall_q   <= en_i & (hi_i[1] ^ lo_i[1]);
      merged_q <= rise_q | fall_q;
      pulse_q  <= 1'b0;
      if (clr_i) begin
        pcnt_q <= '0;
      end else if (merged_q) begin
        pcnt_q  <= pcnt_q + 1'b1;
        pulse_q <= &pcnt_q;
      end
    end
  end

  assign evt_o = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 1'b1;
  end

  a_r1_xor_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (merged_q == $past(en_i && ((hi_i ^ lo_i) != 2'b00), 2)));

  a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rise_q && !fall_q));

  a_r4_pulse_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> ($past(merged_q) && pcnt_q == '0));
endmodule

// File: rtl/eom_rate_divider.sv
module eom_rate_divider
  import eom_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             evt_i,
  output logic             tgl_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [DIV_CW-1:0] cnt_q, lim;
  logic              tgl_q;

  assign lim = ratio_m1(sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (clr_i) begin
      sel_q <= sel_i;
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (evt_i) begin
      if (cnt_q == lim) begin
        cnt_q <= '0;
        tgl_q <= ~tgl_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tgl_o = tgl_q;

  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);

  a_r6_tgl_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tgl_q) && !$past(clr_i)) |-> (cnt_q == '0 && $past(evt_i)));

  a_r7_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(sel_q));

  a_r7_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!tgl_q && cnt_q == '0));
endmodule

// File: rtl/eom_err_counter.sv
module eom_err_counter
  import eom_err_pkg::*;
#(
  parameter int unsigned PRE_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_early_i,
  input  logic       en_late_i,
  input  logic [1:0] div_sel_i,
  input  logic [1:0] early_hi_i,
  input  logic [1:0] early_lo_i,
  input  logic [1:0] late_hi_i,
  input  logic [1:0] late_lo_i,
  output logic       err_tgl_o
);
  logic [NPATH-1:0]      en_v, path_evt, ret_q;
  logic [NPATH-1:0][1:0] hi_v, lo_v;
  logic                  comb_evt;

  assign en_v = {en_late_i, en_early_i};
  assign hi_v = {late_hi_i, early_hi_i};
  assign lo_v = {late_lo_i, early_lo_i};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    eom_mask_path #(.PRE_W(PRE_W)) u_path (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (en_v[p]),
      .hi_i   (hi_v[p]),
      .lo_i   (lo_v[p]),
      .evt_o  (path_evt[p])
    );
  end

  // retime onto the early phase before combining
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ret_q <= '0;
    else         ret_q <= path_evt;
  end

  assign comb_evt = |ret_q;

  eom_rate_divider u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .sel_i  (div_sel_i),
    .evt_i  (comb_evt),
    .tgl_o  (err_tgl_o)
  );

  a_r5_comb_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comb_evt |-> ($past(path_evt) != '0));
endmodule

// File: tb/eom_err_counter_bench.sv
module eom_err_counter_bench;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, en_e = 1'b1, en_l = 1'b1;
  logic [1:0] sel = 2'b00, ehi = '0, elo = '0, lhi = '0, llo = '0;
  logic tgl;

  always #4 clk = ~clk;

  eom_err_counter u_eom_err_counter (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_early_i(en_e), .en_late_i(en_l),
    .div_sel_i(sel), .early_hi_i(ehi), .early_lo_i(elo), .late_hi_i(lhi),
    .late_lo_i(llo), .err_tgl_o(tgl));

  int errs = 0, checks = 0;
  int pe = 0, pl = 0, dc = 0, ratio = 1, exp_tg = 0, obs_tg = 0;
  logic prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit viol(input logic [1:0] h, input logic [1:0] l);
    return (h ^ l) != 2'b00;
  endfunction

  // reference model, advanced once per driven cycle
  task automatic cycle();
    bit e, l, pe_hit, pl_hit;
    e = en_e && viol(ehi, elo);
    l = en_l && viol(lhi, llo);
    pe_hit = 0; pl_hit = 0;
    if (e) begin pe = (pe + 1) % 16; pe_hit = (pe == 0); end
    if (l) begin pl = (pl + 1) % 16; pl_hit = (pl == 0); end
    if (pe_hit || pl_hit) begin
      dc++;
      if (dc == ratio) begin dc = 0; exp_tg++; end
    end
    @(posedge clk);
    @(negedge clk);
    if (tgl !== prev) obs_tg++;
    prev = tgl;
  endtask

  task automatic idle(input int n);
    ehi = '0; elo = '0; lhi = '0; llo = '0;
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic do_clear(input logic [1:0] s);
    idle(8);
    sel = s; clr = 1'b1;
    cycle();
    clr = 1'b0;
    check(tgl == 1'b0, "R7 clear", tgl, 0);
    pe = 0; pl = 0; dc = 0; exp_tg = 0; obs_tg = 0; prev = tgl;
    ratio = 1 << (2 * s);
  endtask

  task automatic drive_viol(input int n, input bit early, input bit late, input logic [1:0] pat);
    for (int i = 0; i < n; i++) begin
      ehi = early ? pat : 2'b00; elo = '0;
      lhi = late  ? pat : 2'b00; llo = '0;
      cycle();
    end
    idle(8);
  endtask

  task automatic drive_rand(input int n);
    for (int i = 0; i < n; i++) begin
      ehi = 2'($urandom); lhi = 2'($urandom);
      elo = ehi ^ (($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00);
      llo = lhi ^ (($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00);
      cycle();
    end
    idle(8);
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic t0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tgl == 1'b0, "R8 reset output", tgl, 0);
    rst_n = 1'b1;
    prev = tgl;

    // R8: code 00 after reset -> 16 events give one toggle
    drive_viol(16, 1, 0, 2'b01);
    check(obs_tg == 1, "R8 default ratio", obs_tg, 1);

    // R1: agreeing slicers never count
    do_clear(2'b00);
    for (int i = 0; i < 200; i++) begin
      ehi = 2'($urandom); elo = ehi; lhi = 2'($urandom); llo = lhi;
      cycle();
    end
    idle(8);
    check(obs_tg == 0, "R1 equal bits", obs_tg, 0);
    drive_viol(32, 0, 1, 2'b10);
    check(obs_tg == 2, "R1 falling-bit xor", obs_tg, 2);

    // R2: both edges in one cycle merge to one event
    do_clear(2'b00);
    drive_viol(32, 1, 0, 2'b11);
    check(obs_tg == 2, "R2 merge edges", obs_tg, 2);

    // R3: disabled path ignored, then counts when enabled
    do_clear(2'b00);
    en_e = 1'b0;
    drive_viol(64, 1, 0, 2'b01);
    check(obs_tg == 0, "R3 early disabled", obs_tg, 0);
    en_e = 1'b1; en_l = 1'b0;
    drive_viol(64, 0, 1, 2'b01);
    check(obs_tg == 0, "R3 late disabled", obs_tg, 0);
    en_l = 1'b1;
    drive_viol(64, 1, 0, 2'b01);
    check(obs_tg == 4, "R3 re-enabled", obs_tg, 4);

    // R5: coincident path events count once
    do_clear(2'b00);
    drive_viol(32, 1, 1, 2'b01);
    check(obs_tg == 2, "R5 coincident OR", obs_tg, 2);

    // R4 + R9: 15 events silent, 16th toggles at fifth edge
    do_clear(2'b00);
    drive_viol(15, 1, 0, 2'b01);
    check(obs_tg == 0, "R4 fifteen events", obs_tg, 0);
    t0 = tgl;
    ehi = 2'b01; elo = 2'b00;
    cycle();
    ehi = 2'b00;
    for (int i = 0; i < 3; i++) cycle();
    check(tgl == t0, "R9 before fifth edge", tgl, t0);
    cycle();
    check(tgl != t0, "R9 fifth edge", tgl, !t0);
    idle(4);
    check(obs_tg == 1, "R4 sixteenth event", obs_tg, 1);

    // R6: each ratio
    for (int s = 0; s < 4; s++) begin
      do_clear(2'(s));
      drive_viol(16 * (1 << (2 * s)) * 2, 1, 0, 2'b10);
      check(obs_tg == 2, $sformatf("R6 ratio code %0d", s), obs_tg, 2);
    end

    // R7: select change without clear ignored
    do_clear(2'b01);
    sel = 2'b11;
    drive_viol(64, 1, 0, 2'b01);
    check(obs_tg == 1, "R7 sel ignored", obs_tg, 1);

    // R6 random against model
    for (int s = 0; s < 4; s++) begin
      do_clear(2'(s));
      drive_rand(3000);
      check(obs_tg == exp_tg, $sformatf("R6 random code %0d", s), obs_tg, exp_tg);
    end

    // R2/R5 random with one side masked
    do_clear(2'b00);
    en_l = 1'b0;
    drive_rand(2000);
    check(obs_tg == exp_tg, "R3 random masked", obs_tg, exp_tg);
    en_l = 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule